// File: doc/BRIEF.md
# Chained Mux Select and ADC Readout Sequencer

This block is the host-side master for a serial chain made of several 8-way channel-select devices followed by a serial ADC. All of them share one serial clock, one outgoing data line, one returning data line and one frame strobe. A caller presents a global channel index with a one-cycle request. The block then runs a single framed transaction. It shifts one 4-bit nibble per chained device, with exactly one device enabled. One idle (null) bit clock follows. Last, it captures a 12-bit conversion word from the return line and presents it with a one-cycle valid strobe.

The global index is split into a device number (index / 8) and a local channel (index mod 8). The serial clock is derived from the system clock by a half-period divider. Outgoing data changes on the falling serial edge, and both sides sample on the rising edge. Between frames the strobe stays low for at least two serial clock periods before a new request is taken.

Top module: `chain_sel_adc_seq`

## Requirements
- R1: After reset, frame_o, sclk_o, mosi_o, busy_o and valid_o are all 0.
- R2: A request is accepted only while busy_o is 0. busy_o is 1 from the cycle after acceptance until the inter-frame gap has ended. A request raised while busy_o is 1 starts no frame and does not change the selection already being sent.
- R3: The select phase sends N_DEV nibbles, device N_DEV-1 first and device 0 last. Each nibble is {enable, c2, c1, c0}, sent MSB first. The target device is chan_i / 8 and the local channel is chan_i mod 8.
- R4: Exactly one nibble has its enable bit set when chan_i < 8*N_DEV. Every other device receives 4'b0000. An index at or above 8*N_DEV sends 4'b0000 to every device.
- R5: One null bit clock follows the select bits. mosi_o is 0 during the null bit and throughout the data phase.
- R6: The 12 return bits are sampled on the rising sclk_o edges that follow the null bit, most significant bit first, and are presented on result_o.
- R7: valid_o pulses high for one cycle in the cycle frame_o falls. result_o holds its value while frame_o is low.
- R8: sclk_o idles low. Its high and low halves each last DIV_HALF system clocks. A frame contains exactly 4*N_DEV+13 rising edges.
- R9: Between frames, frame_o stays low for at least 4*DIV_HALF system clocks. If a request is waiting, it stays low for exactly 4*DIV_HALF+1 clocks.
- R10: frame_o is high for the whole transaction, and sclk_o is low whenever frame_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Conversion request, taken when not busy |
| chan_i | input | IDX_W | Global channel index, IDX_W = clog2(8*N_DEV) |
| busy_o | output | 1 | Transaction or gap in progress |
| valid_o | output | 1 | One-cycle strobe, result_o is new |
| result_o | output | RES_W | Captured conversion word |
| sclk_o | output | 1 | Serial clock to the chain |
| mosi_o | output | 1 | Select bits to the chain |
| miso_i | input | 1 | Returning conversion data |
| frame_o | output | 1 | Active-high frame strobe shared by the chain |

## Verification
A wrong bit counter or shift register shows up within one frame at the serial pins. The rising-edge count per frame changes, a select nibble lands on the wrong device, or a data bit lands one position off in result_o. A divider or gap fault shows up at the next serial edge, as a rise-to-rise spacing or an inter-frame gap that differs from the exact expected time. A handshake fault shows up as an extra frame or a changed selection when a request arrives during a busy period.

// File: rtl/chain_seq_pkg.sv
package chain_seq_pkg;
   localparam int CH_BITS = 3;
   localparam int NIB_W   = CH_BITS + 1;
   localparam int CH_PER_DEV = 1 << CH_BITS;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_GAP   = 2'd2
   } seq_state_t;
endpackage

// File: rtl/edge_timer.sv
module edge_timer #(
   parameter int HALF = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

   if (HALF < 1) begin : g_bad_half
      $error("edge_timer: HALF must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (!run)                cnt <= '0;
      else if (cnt == CW'(HALF-1))  cnt <= '0;
      else                          cnt <= cnt + 1'b1;
   end

   assign tick = run && (cnt == CW'(HALF-1));
endmodule

// File: rtl/sel_frame_build.sv
module sel_frame_build
   import chain_seq_pkg::*;
#(
   parameter int N_DEV = 3,
   parameter int IDX_W = 5
) (
   input  logic [IDX_W-1:0]       chan_i,
   output logic [N_DEV*NIB_W-1:0] word_o
);
   logic [31:0] dev_num;
   assign dev_num = 32'(chan_i) >> CH_BITS;

   for (genvar d = 0; d < N_DEV; d++) begin : g_dev
      logic hit;
      assign hit = (dev_num == 32'(d));
      assign word_o[d*NIB_W +: NIB_W] = hit ? {1'b1, chan_i[CH_BITS-1:0]} : '0;
   end
endmodule

// File: rtl/rx_shift.sv
module rx_shift #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] q
);
   if (W < 2) begin : g_bad_w
      $error("rx_shift: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= {q[W-2:0], din};
   end
endmodule

// File: rtl/chain_sel_adc_seq.sv
module chain_sel_adc_seq
   import chain_seq_pkg::*;
#(
   parameter  int N_DEV    = 3,
   parameter  int DIV_HALF = 13,
   parameter  int RES_W    = 12,
   localparam int IDX_W    = $clog2(N_DEV*CH_PER_DEV)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [IDX_W-1:0] chan_i,
   output logic             busy_o,
   output logic             valid_o,
   output logic [RES_W-1:0] result_o,
   output logic             sclk_o,
   output logic             mosi_o,
   input  logic             miso_i,
   output logic             frame_o
);
   localparam int SEL_BITS = N_DEV * NIB_W;
   localparam int TOT_BITS = SEL_BITS + 1 + RES_W;
   localparam int CNT_W    = $clog2(TOT_BITS);

   if (N_DEV < 1 || N_DEV > 8) begin : g_bad_ndev
      $error("chain_sel_adc_seq: N_DEV must lie in 1..8");
   end
   if (DIV_HALF < 1) begin : g_bad_div
      $error("chain_sel_adc_seq: DIV_HALF must be at least 1");
   end

   seq_state_t          st;
   logic                frame_q, sclk_q, valid_q, tick, rx_en;
   logic [CNT_W-1:0]    bit_cnt;
   logic [SEL_BITS-1:0] tx_sr, sel_word;
   logic [1:0]          gap_cnt;
   logic [N_DEV-1:0]    en_now;

   edge_timer #(.HALF(DIV_HALF)) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (st != ST_IDLE),
      .tick (tick)
   );

   sel_frame_build #(.N_DEV(N_DEV), .IDX_W(IDX_W)) u_bld (
      .chan_i(chan_i),
      .word_o(sel_word)
   );

   assign rx_en = (st == ST_SHIFT) && tick && !sclk_q &&
                  (bit_cnt >= CNT_W'(SEL_BITS + 1));

   rx_shift #(.W(RES_W)) u_rx (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (rx_en),
      .din  (miso_i),
      .q    (result_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         frame_q <= 1'b0;
         sclk_q  <= 1'b0;
         valid_q <= 1'b0;
         bit_cnt <= '0;
         tx_sr   <= '0;
         gap_cnt <= '0;
      end else begin
         valid_q <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (req_i) begin
                  st      <= ST_SHIFT;
                  frame_q <= 1'b1;
                  sclk_q  <= 1'b0;
                  tx_sr   <= sel_word;
                  bit_cnt <= '0;
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (!sclk_q) begin
                     sclk_q <= 1'b1;
                  end else begin
                     sclk_q <= 1'b0;
                     if (bit_cnt == CNT_W'(TOT_BITS - 1)) begin
                        frame_q <= 1'b0;
                        valid_q <= 1'b1;
                        gap_cnt <= '0;
                        st      <= ST_GAP;
                     end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        tx_sr   <= tx_sr << 1;
                     end
                  end
               end
            end
            ST_GAP: begin
               if (tick) begin
                  if (gap_cnt == 2'd3) st <= ST_IDLE;
                  else                 gap_cnt <= gap_cnt + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy_o  = (st != ST_IDLE);
   assign valid_o = valid_q;
   assign sclk_o  = sclk_q;
   assign frame_o = frame_q;
   assign mosi_o  = frame_q && (bit_cnt < CNT_W'(SEL_BITS)) && tx_sr[SEL_BITS-1];

   for (genvar d = 0; d < N_DEV; d++) begin : g_en
      assign en_now[d] = tx_sr[d*NIB_W + NIB_W - 1];
   end

   // R10
   idle_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_q |-> !sclk_q);
   // R7
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q);
   // R7
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_q |=> $stable(result_o));
   // R2
   accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_q) |-> ($past(st) == ST_IDLE));
   // R4
   one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_q) |-> $onehot0(en_now));
   // R9
   gap_frame_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_GAP) |-> !frame_q);
endmodule

// File: tb/test_chain_sel_adc_seq.sv
`timescale 1ns/1ps
module test_chain_sel_adc_seq;
   localparam int N     = 3;
   localparam int DIV   = 13;
   localparam int RW    = 12;
   localparam int SEL   = 4*N;
   localparam int TOT   = SEL + 1 + RW;
   localparam int IW    = $clog2(N*8);
   localparam int TCLK  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic [IW-1:0] chan = '0;
   logic          busy, valid, sclk, mosi, frame;
   logic          miso = 1'b0;
   logic [RW-1:0] result;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(TCLK/2) clk = ~clk;

   chain_sel_adc_seq #(.N_DEV(N), .DIV_HALF(DIV), .RES_W(RW)) i_chain_sel_adc_seq (
      .clk(clk), .rst_n(rst_n), .req_i(req), .chan_i(chan),
      .busy_o(busy), .valid_o(valid), .result_o(result),
      .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .frame_o(frame)
   );

   // behavioural chain + converter model
   logic [RW-1:0]  adc_word = '0;
   logic [SEL-1:0] cap = '0;
   int  rise_k = 0;
   int  bad_tail = 0;
   int  bad_period = 0;
   int  frames = 0;
   time last_rise = 0;
   time fall_t = 0;
   time last_gap = 0;
   int  short_gaps = 0;
   bit  seen_fall = 1'b0;

   always @(posedge frame) begin
      rise_k = 0; bad_tail = 0; frames++;
      if (seen_fall) begin
         last_gap = $time - fall_t;
         if (last_gap < time'(4*DIV*TCLK)) short_gaps++;
      end
   end
   always @(negedge frame) begin
      fall_t = $time; seen_fall = 1'b1;
   end
   always @(posedge sclk) begin
      if (rise_k > 0 && ($time - last_rise) != time'(2*DIV*TCLK)) bad_period++;
      last_rise = $time;
      if (rise_k < SEL) cap = {cap[SEL-2:0], mosi};
      else if (mosi) bad_tail++;
      rise_k++;
   end
   always @(negedge sclk) begin
      if (rise_k >= SEL+1 && rise_k < TOT) miso = adc_word[RW-1-(rise_k-SEL-1)];
      else miso = 1'b0;
   end

   function automatic logic [SEL-1:0] exp_frame(int idx);
      logic [SEL-1:0] w = '0;
      for (int d = 0; d < N; d++)
         if (idx / 8 == d) w[d*4 +: 4] = {1'b1, 3'(idx % 8)};
      return w;
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_valid();
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if (valid) return;
      end
      chk(1'b0, "R7 valid never seen", 0, 1);
   endtask

   task automatic check_result(int idx, logic [RW-1:0] w);
      chk(result == w, "R6 result word", result, w);
      chk(cap == exp_frame(idx), "R3 R4 select frame", cap, exp_frame(idx));
      chk(rise_k == TOT, "R8 rising edges per frame", rise_k, TOT);
      chk(bad_tail == 0, "R5 mosi low after select", bad_tail, 0);
      chk(frame == 1'b0 && busy == 1'b1, "R10 frame low, busy in gap", {frame, busy}, 2'b01);
      @(negedge clk);
      chk(valid == 1'b0, "R7 valid one cycle", valid, 0);
      chk(result == w, "R7 result held", result, w);
   endtask

   task automatic run_txn(int idx, logic [RW-1:0] w);
      while (busy) @(negedge clk);
      adc_word = w;
      chan = IW'(idx);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      chk(busy == 1'b1 && frame == 1'b1, "R2 busy after accept", {busy, frame}, 2'b11);
      wait_valid();
      check_result(idx, w);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1
      chk({frame, sclk, mosi, busy, valid} == 5'b0, "R1 reset outputs",
          {frame, sclk, mosi, busy, valid}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk({frame, sclk, mosi, busy, valid} == 5'b0, "R1 idle after reset",
          {frame, sclk, mosi, busy, valid}, 0);

      // directed corners (R3 R4 R6)
      run_txn(0,  12'h000);
      run_txn(7,  12'hFFF);
      run_txn(8,  12'hA5A);
      run_txn(23, 12'h801);
      run_txn(24, 12'h3C3);   // out of range: all nibbles zero (R4)
      run_txn(31, 12'h001);

      // R2: request during busy is ignored
      begin
         int f0;
         while (busy) @(negedge clk);
         f0 = frames;
         adc_word = 12'h5A5;
         chan = IW'(13);
         req = 1'b1; @(negedge clk); req = 1'b0;
         repeat (100) @(negedge clk);
         chan = IW'(2);
         req = 1'b1; @(negedge clk); req = 1'b0;
         wait_valid();
         check_result(13, 12'h5A5);
         while (busy) @(negedge clk);
         repeat (5) @(negedge clk);
         chk(frames == f0 + 1 && frame == 1'b0, "R2 busy request ignored", frames - f0, 1);
      end

      // R9: held request gives back-to-back frames with minimum gap
      begin
         int f0;
         f0 = frames;
         adc_word = 12'h0F0;
         chan = IW'(17);
         req = 1'b1;
         wait_valid();
         check_result(17, 12'h0F0);
         wait_valid();
         req = 1'b0;
         check_result(17, 12'h0F0);
         chk(last_gap == time'((4*DIV+1)*TCLK), "R9 minimum gap", last_gap, (4*DIV+1)*TCLK);
         chk(frames == f0 + 2, "R2 held request frames", frames - f0, 2);
      end

      // constrained random
      for (int t = 0; t < 20; t++) begin
         int idx;
         logic [RW-1:0] w;
         idx = int'($urandom_range(0, 31));
         w = RW'($urandom);
         run_txn(idx, w);
      end

      chk(bad_period == 0, "R8 sclk period", bad_period, 0);
      chk(short_gaps == 0, "R9 gap length", short_gaps, 0);
      while (busy) @(negedge clk);
      chk(sclk == 1'b0 && frame == 1'b0, "R10 idle sclk low", {sclk, frame}, 0);

      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(200000*TCLK);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule